// File: doc/BRIEF.md
# Successive Approximation Conversion Engine

This block carries out a binary-search analog-to-digital conversion around an external comparator and DAC. A one-hot trial-bit pointer walks from the most significant position down to the least. Under it, an approximation register first tries each bit as a one. The register then keeps or drops that bit according to the comparator. When the pointer has been emptied, the finished code is copied into a result register and a one-cycle strobe announces it.

The surrounding logic presents a sample to the comparator, drives the trial code into the DAC, and pulses `start`. It then waits for `valid`. The comparator input `cmp` must be high when the analog level is below the DAC voltage for the present trial code. The conversion width is a parameter: the default of 4 bits gives codes 0 to 15, and 8, 10 or 12 bits give 0 to 255, 0 to 1023 or 0 to 4095. Reset is synchronous and active high.

Top module: `sar_adc_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `trial_code` and `result` are zero and `done` and `valid` are low.
- R2: A `start` pulse seen while idle clears `trial_code` to zero and reloads the trial pointer at the MSB on that same clock edge.
- R3: One edge after the clearing edge, and one edge after each decision, `trial_code` equals the code accumulated so far with the current trial bit set. Bits are tried from MSB down to LSB, and each step changes at most one bit.
- R4: On the edge after a trial bit is set, that bit is cleared if `cmp` is 1 (the trial is above the input) and kept if `cmp` is 0. The bits above it do not change.
- R5: A full-scale input (`cmp` always 0) walks `trial_code` through 1000, 1100, 1110, 1111 for the 4-bit default.
- R6: `done` is low from the start of a conversion until the final bit has been decided. It then goes high and stays high until the next accepted `start`.
- R7: `valid` is high for exactly one cycle, 2·WIDTH+2 cycles after the cycle in which `start` was sampled, and `done` is high while `valid` is high.
- R8: `result` changes only in the cycle that `valid` rises, and it then holds the final code until the next conversion completes.
- R9: A `start` pulse during a conversion has no effect on the trial-code sequence, the result or the timing.
- R10: With an ideal comparator, every input level from 0 to 2^WIDTH−1 converts to exactly that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| cmp | input | 1 | Comparator: 1 when the input is below the trial voltage |
| trial_code | output | WIDTH | Code driven into the external DAC |
| result | output | WIDTH | Latched code of the last finished conversion |
| done | output | 1 | High when every trial bit has been used |
| valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The assertions check several properties on every cycle. `valid` is never longer than one cycle, and `done` is high whenever `valid` is. `result` never moves outside a `valid` cycle. `done` only falls on an accepted start. Outside a start, the trial code never changes more than one bit per cycle. The exact order of the binary search, the keep-or-clear choice made from the comparator, the 2·WIDTH+2 latency, the immunity to a mid-conversion start, and the correct code for every input level can only be shown by the bench. It does this by checking against its own search model for all sixteen levels.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SET    = 2'd1,
    ST_DECIDE = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_mask_reg.sv
module sar_mask_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_top,
  input  logic             shift,
  output logic [WIDTH-1:0] mask,
  output logic             empty
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || load_top) begin
      mask <= TOP_BIT;
    end else if (shift) begin
      mask <= {1'b0, mask[WIDTH-1:1]};
    end
  end

  assign empty = ~|mask;
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic             pick_clear,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] code
);
  logic [WIDTH-1:0] with_bit;
  logic [WIDTH-1:0] without_bit;
  logic [WIDTH-1:0] next_code;

  assign with_bit    = code | mask;
  assign without_bit = code & ~mask;
  assign next_code   = pick_clear ? without_bit : with_bit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
    end else if (ld) begin
      code <= next_code;
    end
  end
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ld) begin
      q <= d;
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cmp,
  input  logic done,
  output logic mask_init,
  output logic mask_shift,
  output logic sar_clr,
  output logic sar_ld,
  output logic sar_pick_clear,
  output logic res_ld,
  output logic valid
);
  sar_state_e state_q, state_d;

  always_comb begin
    state_d        = state_q;
    mask_init      = 1'b0;
    mask_shift     = 1'b0;
    sar_clr        = 1'b0;
    sar_ld         = 1'b0;
    sar_pick_clear = 1'b0;
    res_ld         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mask_init = 1'b1;
          sar_clr   = 1'b1;
          state_d   = ST_SET;
        end
      end
      ST_SET: begin
        if (done) begin
          res_ld  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          sar_ld  = 1'b1;
          state_d = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        sar_ld         = cmp;
        sar_pick_clear = 1'b1;
        mask_shift     = 1'b1;
        state_d        = ST_SET;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      valid   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid   <= res_ld;
    end
  end
endmodule

// File: rtl/sar_adc_engine.sv
module sar_adc_engine #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             valid
);
  logic [WIDTH-1:0] mask;
  logic mask_init, mask_shift, sar_clr, sar_ld, sar_pick_clear, res_ld;

  sar_mask_reg #(.WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst(rst), .load_top(mask_init), .shift(mask_shift),
    .mask(mask), .empty(done)
  );

  sar_approx_reg #(.WIDTH(WIDTH)) u_approx (
    .clk(clk), .rst(rst), .clr(sar_clr), .ld(sar_ld),
    .pick_clear(sar_pick_clear), .mask(mask), .code(trial_code)
  );

  sar_result_reg #(.WIDTH(WIDTH)) u_result (
    .clk(clk), .rst(rst), .ld(res_ld), .d(trial_code), .q(result)
  );

  sar_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmp(cmp), .done(done),
    .mask_init(mask_init), .mask_shift(mask_shift), .sar_clr(sar_clr),
    .sar_ld(sar_ld), .sar_pick_clear(sar_pick_clear), .res_ld(res_ld),
    .valid(valid)
  );
endmodule

// File: rtl/sar_adc_engine_chk.sv
module sar_adc_engine_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] trial_code,
  input logic [WIDTH-1:0] result,
  input logic             done,
  input logic             valid
);
  // R7
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7
  valid_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(result));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R3
  single_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(start) |-> ($countones(trial_code ^ $past(trial_code)) <= 1));
endmodule

bind sar_adc_engine sar_adc_engine_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .trial_code(trial_code),
  .result(result), .done(done), .valid(valid)
);

// File: tb/test_sar_adc_engine.sv
module test_sar_adc_engine;
  localparam int W = 4;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp;
  logic [W-1:0] trial_code, result;
  logic         done, valid;
  int           vin = 0;
  int           checks = 0;
  int           fails = 0;
  int           cycles = 0;

  always #5 clk = ~clk;

  // ideal comparator: high when the input is below the trial level
  assign cmp = (vin < int'(trial_code));

  sar_adc_engine #(.WIDTH(W)) i_sar_adc_engine (
    .clk(clk), .rst(rst), .start(start), .cmp(cmp),
    .trial_code(trial_code), .result(result), .done(done), .valid(valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
      summary();
    end
  end

  // One conversion; 'poke' pulses start mid-conversion (R9)
  task automatic convert(input int v, input bit poke, input int prev_res);
    int acc = 0;
    vin = v;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R2 trial cleared", trial_code, 0);
    check("R6 done low", done, 0);
    for (int k = W - 1; k >= 0; k--) begin
      @(negedge clk);
      check("R3 trial bit set", trial_code, acc | (1 << k));
      check("R8 result held", result, prev_res);
      if (poke && k == W - 2) start = 1'b1;
      if (!(v < (acc | (1 << k)))) acc = acc | (1 << k);
      @(negedge clk);
      start = 1'b0;
      check("R4 keep or clear", trial_code, acc);
      check("R6 done", done, (k == 0) ? 1 : 0);
      check("R7 no early valid", valid, 0);
    end
    @(negedge clk);
    check("R7 valid at 2N+2", valid, 1);
    check("R10 code", result, v);
    check("R7 done with valid", done, 1);
    @(negedge clk);
    check("R7 single pulse", valid, 0);
    check("R8 result kept", result, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trial", trial_code, 0);
    check("R1 result", result, 0);
    check("R1 done", done, 0);
    check("R1 valid", valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle trial", trial_code, 0);
    check("R1 idle valid", valid, 0);

    // R5: full scale walks 1000,1100,1110,1111
    begin
      int prev = 0;
      vin = FULL;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = W - 1; k >= 0; k--) begin
        prev = prev | (1 << k);
        @(negedge clk);
        check("R5 full-scale step", trial_code, prev);
        @(negedge clk);
      end
      @(negedge clk);
      check("R5 full-scale result", result, FULL);
      @(negedge clk);
    end

    // R10: every level, with R9 mid-conversion start on odd levels
    begin
      int prev_res = FULL;
      for (int v = 0; v <= FULL; v++) begin
        convert(v, v[0], prev_res);
        prev_res = v;
      end
    end

    // R8: input change while idle leaves result alone
    vin = 3;
    repeat (4) @(negedge clk);
    check("R8 idle hold", result, FULL);
    check("R6 done idle", done, 1);
    summary();
  end
endmodule